// File: doc/BRIEF.md
# Conditional Branch, Move and Trap Decision Unit

This unit sits beside the integer pipeline and settles, for one control-flow or conditional instruction at a time, whether the instruction's condition holds. It accepts an 8-bit condition register that carries two flag sets (one produced by 32-bit arithmetic, one by 64-bit arithmetic), a 4-bit condition code, a flag-set select bit, the annul bit, the displacement fields of every branch form, the program counter and one register operand for compare-with-zero forms.

One cycle after a strobe it reports whether a branch or conditional move is taken, the branch target, whether the following instruction is to be annulled, and whether a software trap is requested. Two flag-based branch forms (22-bit and 19-bit displacement), a register-versus-zero branch with a split 16-bit displacement, flag-based and register-based conditional moves, and a conditional trap are covered. Floating-point conditions and the delay-slot machinery belong to other blocks.

Top module: `cbr_eval`

## Requirements
- R1: While reset is held and in the cycle after its release, out_valid, taken, annul_next and trap_req are 0 and target is 0.
- R2: A strobe on in_valid yields out_valid and its results exactly one clock later; a cycle without in_valid yields out_valid = 0 with taken, annul_next, trap_req and target all 0 one clock later.
- R3: Flags are read as N at bit 3, Z at bit 2, V at bit 1, C at bit 0 of the chosen set. cond_code values: 1 Z; 2 Z|(N^V); 3 N^V; 4 C|Z; 5 C; 6 N; 7 V; 9 !Z; 10 !(Z|(N^V)); 11 !(N^V); 12 !(C|Z); 13 !C; 14 !N; 15 !V.
- R4: kind 0 always tests the 32-bit set (flags[3:0]); for kinds 1, 3 and 5, wide_sel = 1 tests the 64-bit set (flags[7:4]) and wide_sel = 0 the 32-bit set.
- R5: cond_code 8 holds unconditionally and cond_code 0 never holds, whatever the flags.
- R6: kind 0 targets pc + sign-extended disp22 * 4; kind 1 targets pc + sign-extended disp19 * 4 (modulo 2^64). Target is computed for branch kinds whether taken or not.
- R7: kinds 2 and 4 use cond_code[2:0] to compare reg_val, as a signed 64-bit value, with zero: 1 ==, 2 <=, 3 <, 5 !=, 6 >, 7 >=; codes 0 and 4 never hold.
- R8: kind 2 targets pc + ((sign-extended rdisp_hi) << 16 | rdisp_lo << 2).
- R9: For branch kinds 0, 1, 2: taken equals the condition; annul_next = annul_bit and (condition false, or kind 0/1 with cond_code 8).
- R10: kind 5 (trap) sets trap_req to the flag condition, with taken, annul_next and target all 0.
- R11: kinds 3 (flag move) and 4 (register move) set taken to the condition, with annul_next, trap_req and target 0.
- R12: kinds 6 and 7 are reserved: out_valid is 1 and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs hold one instruction |
| kind | input | 3 | 0 br22, 1 br19, 2 reg branch, 3 flag move, 4 reg move, 5 trap, 6-7 reserved |
| cond_code | input | 4 | Flag condition, or register test in bits 2:0 |
| wide_sel | input | 1 | Test 64-bit flag set for kinds 1, 3, 5 |
| annul_bit | input | 1 | Annul field of a branch |
| flags | input | 8 | 64-bit NZVC in 7:4, 32-bit NZVC in 3:0 |
| disp22 | input | 22 | Word displacement, kind 0 |
| disp19 | input | 19 | Word displacement, kind 1 |
| rdisp_hi | input | 2 | Signed upper displacement part, kind 2 |
| rdisp_lo | input | 14 | Lower displacement part, kind 2 |
| pc | input | 64 | Address of the instruction |
| reg_val | input | 64 | Register operand for compare-with-zero |
| out_valid | output | 1 | Results valid |
| taken | output | 1 | Branch or move taken |
| target | output | 64 | Branch target address |
| annul_next | output | 1 | Annul the following instruction |
| trap_req | output | 1 | Software trap requested |

## Verification
The taken and annul outcomes normally exclude each other, but a branch-always with its annul bit set raises both in the same cycle, while a branch-never with annul set raises annul alone. The bench provokes both with directed strobes on each flag form and with random codes that land on 0 and 8 among the others, and judges every result against a bench model that restates the annul rule separately from the condition table. An assertion also ties any cycle with both outputs high back to a preceding always code.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int PC_W   = 64;
  localparam int D22_W  = 22;
  localparam int D19_W  = 19;
  localparam int RHI_W  = 2;
  localparam int RLO_W  = 14;
  localparam int FLAG_W = 4;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    K_BR22  = 3'd0,
    K_BR19  = 3'd1,
    K_BRREG = 3'd2,
    K_MOVF  = 3'd3,
    K_MOVR  = 3'd4,
    K_TRAP  = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  localparam logic [CODE_W-1:0] C_NEVER  = 4'd0;
  localparam logic [CODE_W-1:0] C_ALWAYS = 4'd8;

  // Bit 3 of the code inverts the base test selected by bits 2:0.
  function automatic logic flag_test(nzvc_t f, logic [CODE_W-1:0] code);
    logic base;
    case (code[2:0])
      3'd1:    base = f.z;
      3'd2:    base = f.z | (f.n ^ f.v);
      3'd3:    base = f.n ^ f.v;
      3'd4:    base = f.c | f.z;
      3'd5:    base = f.c;
      3'd6:    base = f.n;
      3'd7:    base = f.v;
      default: base = 1'b0;
    endcase
    return base ^ code[3];
  endfunction

  function automatic logic is_branch(kind_e k);
    return (k == K_BR22) || (k == K_BR19) || (k == K_BRREG);
  endfunction

  function automatic logic is_move(kind_e k);
    return (k == K_MOVF) || (k == K_MOVR);
  endfunction

endpackage

// File: rtl/cbr_cond_unit.sv
module cbr_cond_unit
  import cbr_pkg::*;
#(
  parameter int NSETS = 2
) (
  input  logic [NSETS*FLAG_W-1:0] flags,
  input  logic                    use_wide,
  input  logic [CODE_W-1:0]       code,
  output logic                    hit,
  output nzvc_t                   chosen
);
  localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;

  nzvc_t set_arr [NSETS];

  genvar g;
  generate
    for (g = 0; g < NSETS; g++) begin : g_set
      assign set_arr[g] = nzvc_t'(flags[g*FLAG_W +: FLAG_W]);
    end
  endgenerate

  logic [SEL_W-1:0] sel_idx;
  assign sel_idx = SEL_W'(use_wide);

  assign chosen = set_arr[sel_idx];
  assign hit    = flag_test(chosen, code);

endmodule

// File: rtl/cbr_reg_test.sv
module cbr_reg_test #(
  parameter int W = 64
) (
  input  logic [W-1:0] val,
  input  logic [2:0]   code,
  output logic         hit
);
  logic is_zero;
  logic is_neg;
  logic base;

  assign is_zero = (val == '0);
  assign is_neg  = val[W-1];

  always_comb begin
    case (code[1:0])
      2'd1:    base = is_zero;
      2'd2:    base = is_zero | is_neg;
      2'd3:    base = is_neg;
      default: base = 1'b0;
    endcase
  end

  // Bit 2 inverts; codes 0 and 4 stay false.
  assign hit = (code[1:0] == 2'd0) ? 1'b0 : (base ^ code[2]);

endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen
  import cbr_pkg::*;
#(
  parameter int AW   = PC_W,
  parameter int W22  = D22_W,
  parameter int W19  = D19_W,
  parameter int WHI  = RHI_W,
  parameter int WLO  = RLO_W
) (
  input  kind_e           kind,
  input  logic [AW-1:0]   pc,
  input  logic [W22-1:0]  disp22,
  input  logic [W19-1:0]  disp19,
  input  logic [WHI-1:0]  rhi,
  input  logic [WLO-1:0]  rlo,
  output logic [AW-1:0]   target
);
  localparam int HI_SHIFT = WLO + 2;

  function automatic logic [AW-1:0] word_off22(logic [W22-1:0] d);
    logic [AW-1:0] ext;
    ext = {{(AW-W22){d[W22-1]}}, d};
    return ext << 2;
  endfunction

  function automatic logic [AW-1:0] word_off19(logic [W19-1:0] d);
    logic [AW-1:0] ext;
    ext = {{(AW-W19){d[W19-1]}}, d};
    return ext << 2;
  endfunction

  function automatic logic [AW-1:0] split_off(logic [WHI-1:0] h, logic [WLO-1:0] l);
    logic [AW-1:0] hx;
    logic [AW-1:0] lx;
    hx = {{(AW-WHI){h[WHI-1]}}, h};
    lx = {{(AW-WLO){1'b0}}, l};
    return (hx << HI_SHIFT) | (lx << 2);
  endfunction

  logic [AW-1:0] off_sel;

  always_comb begin
    case (kind)
      K_BR22:  off_sel = word_off22(disp22);
      K_BR19:  off_sel = word_off19(disp19);
      K_BRREG: off_sel = split_off(rhi, rlo);
      default: off_sel = '0;
    endcase
  end

  assign target = is_branch(kind) ? (pc + off_sel) : '0;

endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
  import cbr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         kind,
  input  logic [CODE_W-1:0]  cond_code,
  input  logic               wide_sel,
  input  logic               annul_bit,
  input  logic [7:0]         flags,
  input  logic [D22_W-1:0]   disp22,
  input  logic [D19_W-1:0]   disp19,
  input  logic [RHI_W-1:0]   rdisp_hi,
  input  logic [RLO_W-1:0]   rdisp_lo,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    reg_val,
  output logic               out_valid,
  output logic               taken,
  output logic [PC_W-1:0]    target,
  output logic               annul_next,
  output logic               trap_req
);
  localparam int NSETS = 8 / FLAG_W;

  kind_e k;
  assign k = kind_e'(kind);

  // Named internal events.
  logic  use_wide;
  logic  flag_hit;
  logic  reg_hit;
  logic  cond_hit;
  logic  br_kind;
  logic  mv_kind;
  logic  forced_take;
  nzvc_t chosen_set;
  logic [PC_W-1:0] tgt_comb;

  assign use_wide = wide_sel && (k != K_BR22);

  cbr_cond_unit #(.NSETS(NSETS)) u_cond (
    .flags    (flags),
    .use_wide (use_wide),
    .code     (cond_code),
    .hit      (flag_hit),
    .chosen   (chosen_set)
  );

  cbr_reg_test #(.W(PC_W)) u_rtest (
    .val  (reg_val),
    .code (cond_code[2:0]),
    .hit  (reg_hit)
  );

  cbr_target_gen u_tgt (
    .kind   (k),
    .pc     (pc),
    .disp22 (disp22),
    .disp19 (disp19),
    .rhi    (rdisp_hi),
    .rlo    (rdisp_lo),
    .target (tgt_comb)
  );

  assign br_kind     = is_branch(k);
  assign mv_kind     = is_move(k);
  assign cond_hit    = ((k == K_BRREG) || (k == K_MOVR)) ? reg_hit : flag_hit;
  assign forced_take = ((k == K_BR22) || (k == K_BR19)) && (cond_code == C_ALWAYS);

  logic            taken_d;
  logic            annul_d;
  logic            trap_d;
  logic [PC_W-1:0] target_d;

  always_comb begin
    taken_d  = (br_kind || mv_kind) && cond_hit;
    annul_d  = br_kind && annul_bit && (!cond_hit || forced_take);
    trap_d   = (k == K_TRAP) && flag_hit;
    target_d = tgt_comb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      annul_next <= 1'b0;
      trap_req   <= 1'b0;
      target     <= '0;
    end else if (in_valid) begin
      out_valid  <= 1'b1;
      taken      <= taken_d;
      annul_next <= annul_d;
      trap_req   <= trap_d;
      target     <= target_d;
    end else begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      annul_next <= 1'b0;
      trap_req   <= 1'b0;
      target     <= '0;
    end
  end

  // R2: one-cycle latency of the strobe.
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !taken && !annul_next && !trap_req);

  // R1: nothing reported without a valid result.
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (target == '0) && !taken && !trap_req);

  // R5: always code on a flag branch is taken.
  p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && forced_take |=> taken);

  // R9: taken together with annul only follows an always code.
  p_annul_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && taken && annul_next |-> ($past(cond_code) == C_ALWAYS));

  // R10: a trap request excludes branch outcomes.
  p_trap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_req |-> !taken && !annul_next && (target == '0));

  // R11: moves never annul or trap.
  p_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mv_kind |=> !annul_next && !trap_req);

  // R4: the narrow form never looks at the wide set.
  always_comb begin
    if (k == K_BR22) begin
      a_narrow_r4: assert (chosen_set == nzvc_t'(flags[3:0]));
    end
  end

endmodule

// File: tb/cbr_eval_tb.sv
module cbr_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  kind;
  logic [3:0]  cond_code;
  logic        wide_sel;
  logic        annul_bit;
  logic [7:0]  flags;
  logic [21:0] disp22;
  logic [18:0] disp19;
  logic [1:0]  rdisp_hi;
  logic [13:0] rdisp_lo;
  logic [63:0] pc;
  logic [63:0] reg_val;
  logic        out_valid;
  logic        taken;
  logic [63:0] target;
  logic        annul_next;
  logic        trap_req;

  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_eval dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind),
    .cond_code(cond_code), .wide_sel(wide_sel), .annul_bit(annul_bit),
    .flags(flags), .disp22(disp22), .disp19(disp19), .rdisp_hi(rdisp_hi),
    .rdisp_lo(rdisp_lo), .pc(pc), .reg_val(reg_val), .out_valid(out_valid),
    .taken(taken), .target(target), .annul_next(annul_next), .trap_req(trap_req)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Bench model of the condition table (N bit3, Z bit2, V bit1, C bit0).
  function automatic logic m_flag(input logic [3:0] f, input logic [3:0] c);
    logic n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'd0:  return 1'b0;
      4'd8:  return 1'b1;
      4'd1:  return z;
      4'd9:  return !z;
      4'd2:  return z | (n ^ v);
      4'd10: return !(z | (n ^ v));
      4'd3:  return n ^ v;
      4'd11: return !(n ^ v);
      4'd4:  return cy | z;
      4'd12: return !(cy | z);
      4'd5:  return cy;
      4'd13: return !cy;
      4'd6:  return n;
      4'd14: return !n;
      4'd7:  return v;
      default: return !v;
    endcase
  endfunction

  function automatic logic m_reg(input logic [63:0] r, input logic [2:0] c);
    longint s;
    s = longint'(r);
    case (c)
      3'd1: return s == 0;
      3'd2: return s <= 0;
      3'd3: return s < 0;
      3'd5: return s != 0;
      3'd6: return s > 0;
      3'd7: return s >= 0;
      default: return 1'b0;
    endcase
  endfunction

  // Returns {taken, annul, trap, target}.
  function automatic logic [66:0] model();
    logic cnd, tk, an, tr;
    logic [63:0] tg;
    logic [3:0] fs;
    longint off;
    tk = 0; an = 0; tr = 0; tg = 0;
    fs = (wide_sel && kind != 3'd0) ? flags[7:4] : flags[3:0];
    case (kind)
      3'd0, 3'd1: begin
        cnd = m_flag(fs, cond_code);
        if (kind == 3'd0) off = longint'($signed(disp22)) * 4;
        else              off = longint'($signed(disp19)) * 4;
        tg = pc + 64'(off);
        tk = cnd;
        an = annul_bit && (!cnd || cond_code == 4'd8);
      end
      3'd2: begin
        cnd = m_reg(reg_val, cond_code[2:0]);
        off = longint'($signed(rdisp_hi)) * 65536 + longint'(rdisp_lo) * 4;
        tg = pc + 64'(off);
        tk = cnd;
        an = annul_bit && !cnd;
      end
      3'd3: tk = m_flag(fs, cond_code);
      3'd4: tk = m_reg(reg_val, cond_code[2:0]);
      3'd5: tr = m_flag(fs, cond_code);
      default: ;
    endcase
    return {tk, an, tr, tg};
  endfunction

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: return "R3/R6/R9";
      3'd2:       return "R7/R8/R9";
      3'd3, 3'd4: return "R11";
      3'd5:       return "R10";
      default:    return "R12";
    endcase
  endfunction

  // Called on a negedge with inputs driven; checks on the next negedge.
  task automatic run_one(input string req);
    logic [66:0] exp;
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    tests = tests + 1;
    if (!out_valid || {taken, annul_next, trap_req, target} !== exp) begin
      fails = fails + 1;
      $display("FAIL %s kind=%0d code=%0d: actual v=%b t=%b a=%b tr=%b tg=%h expected v=1 t=%b a=%b tr=%b tg=%h",
               req, kind, cond_code, out_valid, taken, annul_next, trap_req, target,
               exp[66], exp[65], exp[64], exp[63:0]);
    end
  endtask

  task automatic check_idle(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    tests = tests + 1;
    if (out_valid || taken || annul_next || trap_req || target != 0) begin
      fails = fails + 1;
      $display("FAIL %s idle: actual v=%b t=%b a=%b tr=%b tg=%h expected all 0",
               req, out_valid, taken, annul_next, trap_req, target);
    end
  endtask

  task automatic set_in(input logic [2:0] k, input logic [3:0] c, input logic ws,
                        input logic a, input logic [7:0] f);
    kind = k; cond_code = c; wide_sel = ws; annul_bit = a; flags = f;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0c0d;
    void'($urandom(seed));
    rst_n = 0; in_valid = 1; kind = 0; cond_code = 8; wide_sel = 0; annul_bit = 1;
    flags = 0; disp22 = 1; disp19 = 1; rdisp_hi = 0; rdisp_lo = 1;
    pc = 64'h1000; reg_val = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset despite a strobe
    tests = tests + 1;
    if (out_valid || taken || annul_next || trap_req || target != 0) begin
      fails = fails + 1;
      $display("FAIL R1 reset: actual v=%b t=%b a=%b tr=%b tg=%h expected all 0",
               out_valid, taken, annul_next, trap_req, target);
    end
    in_valid = 0;
    rst_n = 1;
    check_idle("R1");

    // R5/R9: always with annul on both flag forms -> taken and annul together
    pc = 64'h4000; disp22 = 22'h3FFFFF; disp19 = 19'h40000;
    set_in(3'd0, 4'd8, 1'b0, 1'b1, 8'h00); run_one("R5/R9 always-annul br22");
    set_in(3'd1, 4'd8, 1'b1, 1'b1, 8'hFF); run_one("R5/R9 always-annul br19");
    // R5/R9: never with annul -> annul only
    set_in(3'd0, 4'd0, 1'b0, 1'b1, 8'hFF); run_one("R5/R9 never-annul");
    set_in(3'd1, 4'd0, 1'b1, 1'b0, 8'hFF); run_one("R5 never no annul");
    check_idle("R2");
    // R4: wide and narrow sets differ (wide Z=1, narrow Z=0), code e
    set_in(3'd1, 4'd1, 1'b1, 1'b0, 8'h40); run_one("R4 wide set");
    set_in(3'd1, 4'd1, 1'b0, 1'b0, 8'h40); run_one("R4 narrow set");
    set_in(3'd0, 4'd1, 1'b1, 1'b0, 8'h40); run_one("R4 br22 ignores wide_sel");
    set_in(3'd5, 4'd1, 1'b1, 1'b0, 8'h40); run_one("R4/R10 trap wide");
    // R7: register tests at 0, -1 and min value, including reserved codes
    for (int c = 0; c < 8; c++) begin
      reg_val = 64'h0;                 set_in(3'd2, 4'(c), 1'b0, 1'b1, 8'h00); run_one("R7 reg zero");
      reg_val = 64'hFFFF_FFFF_FFFF_FFFF; set_in(3'd2, 4'(c), 1'b0, 1'b0, 8'h00); run_one("R7 reg neg");
      reg_val = 64'h8000_0000_0000_0000; set_in(3'd4, 4'(c), 1'b0, 1'b0, 8'h00); run_one("R7/R11 reg min");
    end
    // R8: extreme split displacements
    rdisp_hi = 2'b10; rdisp_lo = 14'h0; reg_val = 0;
    set_in(3'd2, 4'd1, 1'b0, 1'b0, 8'h00); run_one("R8 most negative");
    rdisp_hi = 2'b01; rdisp_lo = 14'h3FFF; pc = 64'hFFFF_FFFF_FFFF_FFF0;
    set_in(3'd2, 4'd1, 1'b0, 1'b0, 8'h00); run_one("R8 wrap");
    // R12 reserved kinds
    set_in(3'd6, 4'd8, 1'b0, 1'b1, 8'hFF); run_one("R12 rsv6");
    set_in(3'd7, 4'd8, 1'b1, 1'b1, 8'hFF); run_one("R12 rsv7");
    check_idle("R2");

    // Random mix, all condition codes
    for (int i = 0; i < N_RANDOM; i++) begin
      kind = 3'($urandom_range(0, 7));
      cond_code = 4'($urandom());
      wide_sel = 1'($urandom());
      annul_bit = 1'($urandom());
      flags = 8'($urandom());
      disp22 = 22'($urandom());
      disp19 = 19'($urandom());
      rdisp_hi = 2'($urandom());
      rdisp_lo = 14'($urandom());
      pc = {32'($urandom()), 32'($urandom())};
      case ($urandom_range(0, 3))
        0: reg_val = 64'h0;
        1: reg_val = {32'($urandom()), 32'($urandom())} | 64'h8000_0000_0000_0000;
        default: reg_val = {32'($urandom()), 32'($urandom())};
      endcase
      run_one(req_of(kind));
      if ((i % 97) == 0) check_idle("R2");
    end
    check_idle("R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule